// File: doc/BRIEF.md
# Pipelined YCbCr to RGB Color Converter

This block turns a stream of 8-bit luma and chroma samples (Y, Cb, Cr) into 8-bit red, green and blue values. Each pixel is converted in fixed-point arithmetic. The luma black level and the chroma midpoint are removed first. The offset-corrected samples are then multiplied by integer coefficients that carry eleven fractional bits. Each sum is rounded, shifted back down and clamped to the 0 to 255 range.

The block sits between a video decoder and a display path. It accepts one pixel every clock and has a fixed latency of three clocks. A pixel-valid flag and a group of sideband bits (blanking and sync) pass through the same number of stages, so they leave the block aligned with the pixel they arrived with.

Top module: `ycbcr_to_rgb`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by exactly 3 rising clock edges.
- R2: With ys = Y-16, cr = Cr-128 and fr(s) = floor((s+1024)/2048), the red output equals fr(2384*ys + 3269*cr) when that value lies in 0..255.
- R3: With cb = Cb-128, the green output equals fr(2384*ys - 1665*cr - 803*cb) when that value lies in 0..255. For an input with Cb = Cr = 128, all three outputs are equal.
- R4: The blue output equals fr(2384*ys + 4131*cb) when that value lies in 0..255.
- R5: A channel whose rounded value is negative outputs 0. For example, Y=0 and Cr=0 give red 0.
- R6: A channel whose rounded value exceeds 255 outputs 255. For example, Y=255 and Cb=255 give blue 255.
- R7: `side_o` equals `side_i` delayed by exactly 3 rising clock edges, whatever the value of `valid_i`.
- R8: While `rst_ni` is low, `valid_o`, `side_o`, `r_o`, `g_o` and `b_o` are all 0.
- R9: Nominal black (Y=16, Cb=Cr=128) converts to 0,0,0. Nominal white (Y=235, Cb=Cr=128) converts to 255,255,255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel is valid |
| y_i | input | 8 | Luma sample |
| cb_i | input | 8 | Blue-difference chroma sample |
| cr_i | input | 8 | Red-difference chroma sample |
| side_i | input | SB_W (2) | Sideband bits (blanking, sync) |
| valid_o | output | 1 | Output pixel is valid |
| r_o | output | 8 | Red result |
| g_o | output | 8 | Green result |
| b_o | output | 8 | Blue result |
| side_o | output | SB_W (2) | Sideband bits aligned with the output |

## Verification
The assertions check on every cycle that the valid flag and the sideband bits arrive exactly three clocks late. They also check four fixed facts: achromatic input gives equal channels, nominal black gives zero, and the two saturating corners clamp to 0 and to 255. Only the bench scenarios can show the exact rounded values of each channel across the input range. The bench compares every valid output against the formulas, using random pixels mixed with directed corners. It also checks that data gaps leave the sideband timing unchanged.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  localparam int PIX_W    = 8;
  localparam int DIFF_W   = PIX_W + 1;
  localparam int FRAC_SH  = 11;
  localparam int COEF_W   = 14;
  localparam int ACC_W    = 22;
  localparam int PIPE_LAT = 3;

  localparam int Y_OFS = 16;
  localparam int C_OFS = 128;

  localparam int K_Y    = 2384;
  localparam int K_R_CR = 3269;
  localparam int K_G_CR = 1665;
  localparam int K_G_CB = 803;
  localparam int K_B_CB = 4131;

  typedef logic signed [DIFF_W-1:0] diff_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic [PIX_W-1:0]         pix_t;
endpackage

// File: rtl/ycc_delay_line.sv
module ycc_delay_line #(
  parameter int W     = 1,
  parameter int DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] tap [DEPTH+1];
  assign tap[0] = d_i;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap[s+1] <= '0;
      else         tap[s+1] <= tap[s];
    end
  end

  assign q_o = tap[DEPTH];
endmodule

// File: rtl/ycc_offset_stage.sv
module ycc_offset_stage
  import ycc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  pix_t  y_i,
  input  pix_t  cb_i,
  input  pix_t  cr_i,
  output diff_t ys_o,
  output diff_t cbs_o,
  output diff_t crs_o
);
  localparam diff_t YO = diff_t'(Y_OFS);
  localparam diff_t CO = diff_t'(C_OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ys_o  <= '0;
      cbs_o <= '0;
      crs_o <= '0;
    end else begin
      ys_o  <= $signed({1'b0, y_i})  - YO;
      cbs_o <= $signed({1'b0, cb_i}) - CO;
      crs_o <= $signed({1'b0, cr_i}) - CO;
    end
  end
endmodule

// File: rtl/ycc_matrix_stage.sv
module ycc_matrix_stage
  import ycc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  diff_t ys_i,
  input  diff_t cbs_i,
  input  diff_t crs_i,
  output acc_t  r_acc_o,
  output acc_t  g_acc_o,
  output acc_t  b_acc_o
);
  localparam acc_t CY  = acc_t'(K_Y);
  localparam acc_t CRR = acc_t'(K_R_CR);
  localparam acc_t CGR = acc_t'(K_G_CR);
  localparam acc_t CGB = acc_t'(K_G_CB);
  localparam acc_t CBB = acc_t'(K_B_CB);

  acc_t y_x, cb_x, cr_x;
  acc_t py, prr, pgr, pgb, pbb;

  // sign-extend offset-corrected samples to accumulator width
  assign y_x  = {{(ACC_W-DIFF_W){ys_i[DIFF_W-1]}},  ys_i};
  assign cb_x = {{(ACC_W-DIFF_W){cbs_i[DIFF_W-1]}}, cbs_i};
  assign cr_x = {{(ACC_W-DIFF_W){crs_i[DIFF_W-1]}}, crs_i};

  assign py  = y_x  * CY;
  assign prr = cr_x * CRR;
  assign pgr = cr_x * CGR;
  assign pgb = cb_x * CGB;
  assign pbb = cb_x * CBB;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_acc_o <= '0;
      g_acc_o <= '0;
      b_acc_o <= '0;
    end else begin
      r_acc_o <= py + prr;
      g_acc_o <= py - pgr - pgb;
      b_acc_o <= py + pbb;
    end
  end
endmodule

// File: rtl/ycc_clamp_stage.sv
module ycc_clamp_stage
  import ycc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  acc_t acc_i,
  output pix_t pix_o
);
  localparam acc_t HALF = acc_t'(1 << (FRAC_SH - 1));
  localparam acc_t PMAX = acc_t'((1 << PIX_W) - 1);

  acc_t rnd, shr;
  pix_t sat;

  assign rnd = acc_i + HALF;
  assign shr = rnd >>> FRAC_SH;

  always_comb begin
    if (shr[ACC_W-1])   sat = '0;
    else if (shr > PMAX) sat = '1;
    else                sat = shr[PIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= '0;
    else         pix_o <= sat;
  end
endmodule

// File: rtl/ycbcr_to_rgb.sv
module ycbcr_to_rgb
  import ycc_pkg::*;
#(
  parameter int SB_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [7:0]      y_i,
  input  logic [7:0]      cb_i,
  input  logic [7:0]      cr_i,
  input  logic [SB_W-1:0] side_i,
  output logic            valid_o,
  output logic [7:0]      r_o,
  output logic [7:0]      g_o,
  output logic [7:0]      b_o,
  output logic [SB_W-1:0] side_o
);
  localparam int TAG_W = SB_W + 1;

  diff_t ys, cbs, crs;
  acc_t  acc [3];
  pix_t  pix [3];

  ycc_offset_stage i_ofs (
    .clk_i, .rst_ni,
    .y_i, .cb_i, .cr_i,
    .ys_o(ys), .cbs_o(cbs), .crs_o(crs)
  );

  ycc_matrix_stage i_mat (
    .clk_i, .rst_ni,
    .ys_i(ys), .cbs_i(cbs), .crs_i(crs),
    .r_acc_o(acc[0]), .g_acc_o(acc[1]), .b_acc_o(acc[2])
  );

  for (genvar c = 0; c < 3; c++) begin : g_chan
    ycc_clamp_stage i_clamp (
      .clk_i, .rst_ni,
      .acc_i(acc[c]),
      .pix_o(pix[c])
    );
  end

  assign r_o = pix[0];
  assign g_o = pix[1];
  assign b_o = pix[2];

  ycc_delay_line #(.W(TAG_W), .DEPTH(PIPE_LAT)) i_tag (
    .clk_i, .rst_ni,
    .d_i({valid_i, side_i}),
    .q_o({valid_o, side_o})
  );
endmodule

// File: rtl/ycbcr_to_rgb_chk.sv
module ycbcr_to_rgb_chk #(
  parameter int SB_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [7:0]      y_i,
  input logic [7:0]      cb_i,
  input logic [7:0]      cr_i,
  input logic [SB_W-1:0] side_i,
  input logic            valid_o,
  input logic [7:0]      r_o,
  input logic [7:0]      g_o,
  input logic [7:0]      b_o,
  input logic [SB_W-1:0] side_o
);
  logic [1:0] age;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign warm = (age == 2'd3);

  always_comb begin
    if (!rst_ni) AST_RESET_QUIET: assert (!valid_o && side_o == '0 && r_o == '0 && g_o == '0 && b_o == '0); // R8
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> valid_o == $past(valid_i, 3)); // R1
  AST_SIDE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> side_o == $past(side_i, 3)); // R7
  AST_GRAY_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(valid_i && cb_i == 8'd128 && cr_i == 8'd128, 3)) |-> (r_o == g_o && g_o == b_o)); // R3
  AST_BLACK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(y_i == 8'd16 && cb_i == 8'd128 && cr_i == 8'd128, 3)) |-> (r_o == 8'd0 && g_o == 8'd0 && b_o == 8'd0)); // R9
  AST_CLAMP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(y_i == 8'd0 && cr_i == 8'd0, 3)) |-> r_o == 8'd0); // R5
  AST_CLAMP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(y_i == 8'd255 && cb_i == 8'd255, 3)) |-> b_o == 8'd255); // R6
endmodule

bind ycbcr_to_rgb ycbcr_to_rgb_chk #(.SB_W(SB_W)) i_chk (.*);

// File: tb/test_ycbcr_to_rgb.sv
module test_ycbcr_to_rgb;
  localparam int SB_W = 2;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [7:0]      y_i = '0, cb_i = '0, cr_i = '0;
  logic [SB_W-1:0] side_i = '0;
  logic            valid_o;
  logic [7:0]      r_o, g_o, b_o;
  logic [SB_W-1:0] side_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  ycbcr_to_rgb #(.SB_W(SB_W)) i_ycbcr_to_rgb (
    .clk_i(clk), .rst_ni, .valid_i, .y_i, .cb_i, .cr_i, .side_i,
    .valid_o, .r_o, .g_o, .b_o, .side_o
  );

  // entry: {valid, side, y, cb, cr}
  typedef logic [1+SB_W+24-1:0] ent_t;
  ent_t pend[$];

  function automatic int rnd_raw(int s);
    return (s + 1024) >>> 11;
  endfunction

  function automatic int sat(int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag(int raw, string base);
    return (raw < 0) ? "R5" : (raw > 255) ? "R6" : base;
  endfunction

  task automatic check_front();
    ent_t e = pend.pop_front();
    int ys, cbv, crv, rr, gr, br;
    ys  = int'(e[23:16]) - 16;
    cbv = int'(e[15:8]) - 128;
    crv = int'(e[7:0]) - 128;
    rr = rnd_raw(2384*ys + 3269*crv);
    gr = rnd_raw(2384*ys - 1665*crv - 803*cbv);
    br = rnd_raw(2384*ys + 4131*cbv);
    chk("R1", int'(valid_o), int'(e[1+SB_W+23]));
    chk("R7", int'(side_o), int'(e[SB_W+23:24]));
    if (e[1+SB_W+23]) begin
      chk(tag(rr, "R2"), int'(r_o), sat(rr));
      chk(tag(gr, "R3"), int'(g_o), sat(gr));
      chk(tag(br, "R4"), int'(b_o), sat(br));
    end
  endtask

  task automatic step(bit v, logic [SB_W-1:0] sb, logic [7:0] y, logic [7:0] cb, logic [7:0] cr);
    @(negedge clk);
    if (pend.size() == 3) check_front();
    valid_i = v; side_i = sb; y_i = y; cb_i = cb; cr_i = cr;
    pend.push_back({v, sb, y, cb, cr});
  endtask

  initial begin
    void'($urandom(32'd2025));
    // inputs wiggle under reset, outputs must stay cleared (R8)
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      valid_i = 1'b1; side_i = 2'b11; y_i = 8'd200; cb_i = 8'd40; cr_i = 8'd220;
      chk("R8", int'(valid_o), 0);
      chk("R8", int'(side_o), 0);
      chk("R8", int'({r_o, g_o, b_o}), 0);
    end
    pend.push_back('0);
    pend.push_back('0);
    @(negedge clk);
    rst_ni = 1'b1;
    valid_i = 1'b0; side_i = '0; y_i = '0; cb_i = '0; cr_i = '0;
    pend.push_back('0);

    // directed corners: R9 black/white, R5/R6 clamps, full-range extremes
    step(1, 2'b00, 8'd16,  8'd128, 8'd128);
    step(1, 2'b01, 8'd235, 8'd128, 8'd128);
    step(1, 2'b10, 8'd0,   8'd128, 8'd0);
    step(1, 2'b11, 8'd255, 8'd255, 8'd128);
    step(1, 2'b00, 8'd0,   8'd0,   8'd0);
    step(1, 2'b01, 8'd255, 8'd255, 8'd255);
    step(1, 2'b10, 8'd255, 8'd0,   8'd255);
    step(1, 2'b00, 8'd0,   8'd255, 8'd0);
    step(1, 2'b00, 8'd126, 8'd16,  8'd240);
    step(1, 2'b00, 8'd81,  8'd90,  8'd240);
    // valid gaps with sideband still moving (R1, R7)
    step(0, 2'b11, 8'd99,  8'd1,   8'd2);
    step(0, 2'b01, 8'd3,   8'd4,   8'd5);
    step(1, 2'b10, 8'd128, 8'd128, 8'd128);

    // luma sweep at neutral chroma (R3 gray equality)
    for (int y = 0; y < 256; y += 5) step(1, 2'(y), 8'(y), 8'd128, 8'd128);

    // constrained random: nominal ranges mixed with full range
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] y, cb, cr;
      if (($urandom % 4) != 0) begin
        y  = 8'(16 + $urandom % 220);
        cb = 8'(16 + $urandom % 225);
        cr = 8'(16 + $urandom % 225);
      end else begin
        y = 8'($urandom); cb = 8'($urandom); cr = 8'($urandom);
      end
      step(($urandom % 5) != 0, 2'($urandom), y, cb, cr);
    end

    // drain
    for (int i = 0; i < 3; i++) step(0, 2'b00, 8'd0, 8'd0, 8'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule